// File: doc/BRIEF.md
# Memory-Operand Instruction Executor

This block carries out the memory-operand half of a small 16-bit accumulator machine that has a 12-bit word address space. A sequencer fetches an instruction word and hands it to the executor together with the current accumulator, carry flag and program counter. The program counter it passes in already points at the word after the instruction. The executor then runs the operation against a synchronous single-port memory and returns the updated accumulator, carry and program counter. It raises a one-cycle completion pulse, and on that pulse the sequencer may begin the next fetch.

Every operation can name its operand directly or through a pointer word held in memory. The pointer form costs one extra read. Two operations are read-modify-write sequences: the subroutine call stores a return address in memory, and the increment-and-test stores the incremented word back and may skip the next instruction. The memory returns read data one cycle after it samples the address. The executor always spends one waiting state between presenting an address and using the data that comes back.

Top module: `mem_op_exec`

## Requirements
- R1: While reset is low and after it is released, `done` and `mem_we` are low and `acc_q`, `cy_q` and `pc_q` are zero.
- R2: Instruction fields: bit 15 selects pointer mode, bits 14..12 give the operation, and bits 11..0 give the operand address. Operation codes are 0 AND, 1 ADD, 2 LDA, 3 STA, 4 BUN, 5 BSA and 6 ISZ. Code 7 completes one cycle after start and changes nothing.
- R3: In pointer mode, the effective address is bits 11..0 of the word read at the operand address. Pointer mode adds two cycles to the operation.
- R4: AND sets the accumulator to the accumulator ANDed with the memory word. The carry is unchanged.
- R5: ADD sets the accumulator to the 16-bit two's-complement sum of the accumulator and the memory word. The carry out of bit 15 goes to the carry flag.
- R6: LDA loads the memory word into the accumulator. The carry is unchanged.
- R7: STA writes the accumulator to the effective address.
- R8: BUN sets the program counter to the effective address.
- R9: BSA writes the incoming program counter, zero-extended, to the effective address and sets the program counter to the effective address plus one. A later pointer-mode BUN through that word therefore returns to the caller.
- R10: ISZ writes the memory word plus one back to the effective address. If the result is zero, the program counter advances by one extra.
- R11: `done` is a one-cycle pulse. Counted in cycles after the start edge, and before pointer-mode extra cycles are added, it appears in cycle 3 for AND/ADD/LDA, cycle 4 for ISZ, cycle 2 for STA/BSA, and cycle 1 for BUN and code 7.
- R12: A `start` that arrives while an operation is in progress is ignored.
- R13: `mem_we` is high for exactly one cycle per write, in the cycle just before `done`. Operations that do not write never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin executing `instr` (taken only when idle) |
| instr | input | 16 | Instruction word |
| acc_in | input | 16 | Accumulator value at start |
| cy_in | input | 1 | Carry flag at start |
| pc_in | input | 12 | Address of the word following the instruction |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Memory read data, one cycle after the address is sampled |
| acc_q | output | 16 | Resulting accumulator |
| cy_q | output | 1 | Resulting carry flag |
| pc_q | output | 12 | Resulting program counter |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong state transition in this block shows at the ports on the cycle it happens: `done` or `mem_we` rises a cycle early or late, or fails to rise. The bench follows the expected cycle count of every operation and so catches this at once. A wrong effective address or a wrong data path cannot be seen until the completion cycle. At that point the returned accumulator, carry or program counter differs, or the word at the effective address in the bench's memory differs from the reference. A pointer-mode error appears as an access to a different word entirely.

// File: rtl/mem_op_exec.sv
module mem_op_exec #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] instr,
  input  logic [DW-1:0] acc_in,
  input  logic          cy_in,
  input  logic [AW-1:0] pc_in,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] acc_q,
  output logic          cy_q,
  output logic [AW-1:0] pc_q,
  output logic          done
);
  localparam logic [2:0] OP_AND = 3'd0, OP_ADD = 3'd1, OP_LDA = 3'd2, OP_STA = 3'd3,
                         OP_BUN = 3'd4, OP_BSA = 3'd5, OP_ISZ = 3'd6, OP_NOP = 3'd7;
  localparam logic [DW-1:0] ALL_ONES = '1;

  typedef enum logic [2:0] {IDLE, PTR_W, PTR_U, OP_W, OP_U, WRITE, FIN} st_t;
  st_t st;

  logic [2:0]    op;
  logic [AW-1:0] ea;
  logic [DW-1:0] wd;

  function automatic st_t route(input logic [2:0] o);
    case (o)
      OP_AND, OP_ADD, OP_LDA, OP_ISZ: route = OP_W;
      OP_STA, OP_BSA:                 route = WRITE;
      default:                        route = FIN;
    endcase
  endfunction

  assign mem_addr  = ea;
  assign mem_wdata = wd;
  assign mem_we    = (st == WRITE);
  assign done      = (st == FIN);

  wire [2:0] new_op = instr[DW-2 -: 3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= IDLE;
      op    <= OP_AND;
      ea    <= '0;
      wd    <= '0;
      acc_q <= '0;
      cy_q  <= 1'b0;
      pc_q  <= '0;
    end else begin
      case (st)
        IDLE: if (start) begin
          op    <= new_op;
          acc_q <= acc_in;
          cy_q  <= cy_in;
          pc_q  <= pc_in;
          ea    <= instr[AW-1:0];
          wd    <= (new_op == OP_BSA) ? {{(DW-AW){1'b0}}, pc_in} : acc_in;
          if (new_op == OP_NOP)
            st <= FIN;
          else if (instr[DW-1])
            st <= PTR_W;
          else begin
            if (new_op == OP_BUN) pc_q <= instr[AW-1:0];
            st <= route(new_op);
          end
        end
        PTR_W: st <= PTR_U;
        PTR_U: begin
          ea <= mem_rdata[AW-1:0];
          if (op == OP_BUN) pc_q <= mem_rdata[AW-1:0];
          st <= route(op);
        end
        OP_W: st <= OP_U;
        OP_U: begin
          case (op)
            OP_AND: acc_q <= acc_q & mem_rdata;
            OP_ADD: {cy_q, acc_q} <= {1'b0, acc_q} + {1'b0, mem_rdata};
            OP_LDA: acc_q <= mem_rdata;
            OP_ISZ: begin
              wd <= mem_rdata + 1'b1;
              if (mem_rdata == ALL_ONES) pc_q <= pc_q + 1'b1;
            end
            default: ;
          endcase
          st <= (op == OP_ISZ) ? WRITE : FIN;
        end
        WRITE: begin
          if (op == OP_BSA) pc_q <= ea + 1'b1;
          st <= FIN;
        end
        FIN: st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module mem_op_exec_chk (
  input logic clk,
  input logic rst_n,
  input logic done,
  input logic mem_we
);
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  assert_we_then_done_R13: assert property (@(posedge clk) disable iff (!rst_n) mem_we |=> done);
  assert_we_single_R13: assert property (@(posedge clk) disable iff (!rst_n) mem_we |=> !mem_we);
  assert_no_we_at_done_R13: assert property (@(posedge clk) disable iff (!rst_n) done |-> !mem_we);
endmodule

bind mem_op_exec mem_op_exec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .mem_we(mem_we)
);

// File: tb/sim_mem_op_exec.sv
module sim_mem_op_exec;
  logic clk = 0, rst_n = 0, start = 0, cy_in = 0;
  logic [15:0] instr = 0, acc_in = 0, mem_rdata;
  logic [11:0] pc_in = 0, mem_addr, pc_q;
  logic [15:0] mem_wdata, acc_q;
  logic mem_we, cy_q, done;
  logic [15:0] mem [4096];
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mem_op_exec u0 (.clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .acc_in(acc_in),
    .cy_in(cy_in), .pc_in(pc_in), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .acc_q(acc_q), .cy_q(cy_q), .pc_q(pc_q), .done(done));

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] ins, input logic [15:0] a, input bit c,
                     input logic [11:0] p, input bit poke, input string req);
    logic [2:0] op = ins[14:12];
    bit ind = ins[15];
    logic [11:0] ea = ind ? mem[ins[11:0]][11:0] : ins[11:0];
    logic [15:0] m = mem[ea];
    logic [15:0] ea_ac = a, exp_w = m;
    bit exp_c = c, wr = 0;
    logic [11:0] exp_pc = p;
    logic [16:0] s;
    int n;
    case (op)
      3'd0: begin ea_ac = a & m; n = 3; end
      3'd1: begin s = {1'b0, a} + {1'b0, m}; ea_ac = s[15:0]; exp_c = s[16]; n = 3; end
      3'd2: begin ea_ac = m; n = 3; end
      3'd3: begin exp_w = a; wr = 1; n = 2; end
      3'd4: begin exp_pc = ea; n = 1; end
      3'd5: begin exp_w = {4'h0, p}; exp_pc = ea + 12'd1; wr = 1; n = 2; end
      3'd6: begin exp_w = m + 16'd1; if (exp_w == 0) exp_pc = p + 12'd1; wr = 1; n = 4; end
      default: n = 1;
    endcase
    if (ind && op != 3'd7) n += 2;
    @(negedge clk);
    instr = ins; acc_in = a; cy_in = c; pc_in = p; start = 1;
    @(negedge clk);
    for (int k = 1; k <= n + 2; k++) begin
      start = (poke && k == 1);
      if (poke && k == 1) instr = 16'h2000;
      chk(done == (k == n), {req, " R11 done timing"}, done, (k == n));
      chk(mem_we == (wr && k == n - 1), {req, " R13 write strobe"}, mem_we, (wr && k == n - 1));
      if (k == n) begin
        chk(acc_q == ea_ac, {req, " acc"}, acc_q, ea_ac);
        chk(cy_q == exp_c, {req, " carry"}, cy_q, exp_c);
        chk(pc_q == exp_pc, {req, " pc"}, pc_q, exp_pc);
        chk(mem[ea] == exp_w, {req, " memory word"}, mem[ea], exp_w);
      end
      @(negedge clk);
    end
    start = 0;
  endtask

  initial begin : wd
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0;
    mem[12'h100] = 16'h0F0F;
    mem[12'h101] = 16'h0001;
    mem[12'h102] = 16'h1234;
    mem[12'h103] = 16'hFFFF;
    mem[12'h104] = 16'h0005;
    mem[12'h200] = 16'hA102;
    mem[12'h201] = 16'h0300;
    mem[12'h202] = 16'h0104;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(done == 0 && mem_we == 0, "R1 strobes", {done, mem_we}, 0);
    chk(acc_q == 0 && cy_q == 0 && pc_q == 0, "R1 outputs", {acc_q, cy_q, pc_q}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(done == 0 && acc_q == 0 && pc_q == 0, "R1 after release", {done, acc_q, pc_q}, 0);
    run(16'h0100, 16'h33FF, 1'b1, 12'h011, 0, "R4 AND direct, R2");
    run(16'h1101, 16'h0041, 1'b1, 12'h012, 0, "R5 ADD no carry");
    run(16'h1103, 16'h0001, 1'b0, 12'h013, 1, "R5 ADD carry out, R12 poke");
    run(16'h2102, 16'h0000, 1'b1, 12'h014, 0, "R6 LDA direct");
    run(16'hA200, 16'h0000, 1'b0, 12'h015, 0, "R3 R6 LDA pointer");
    run(16'h3300, 16'hBEEF, 1'b0, 12'h016, 1, "R7 STA direct, R12");
    run(16'hB201, 16'hCAFE, 1'b1, 12'h017, 0, "R3 R7 STA pointer");
    run(16'h4456, 16'h0000, 1'b0, 12'h018, 0, "R8 BUN direct");
    run(16'hC202, 16'h0000, 1'b0, 12'h019, 0, "R3 R8 BUN pointer");
    run(16'h5400, 16'h1111, 1'b0, 12'h021, 0, "R9 BSA direct");
    run(16'hC400, 16'h0000, 1'b0, 12'h401, 0, "R9 return via pointer BUN");
    run(16'hD202, 16'h0000, 1'b0, 12'h031, 0, "R3 R9 BSA pointer");
    run(16'h6101, 16'h0000, 1'b0, 12'h041, 0, "R10 ISZ no skip");
    run(16'h6103, 16'h0000, 1'b1, 12'h042, 1, "R10 ISZ skip, R12");
    run(16'hE202, 16'h0000, 1'b0, 12'h043, 0, "R3 R10 ISZ pointer");
    run(16'h7123, 16'h5555, 1'b1, 12'h050, 0, "R2 code 7 no change");
    run(16'hF123, 16'h5555, 1'b0, 12'h051, 0, "R2 code 7 pointer bit");
    run(16'h8100, 16'hFFFF, 1'b0, 12'h052, 0, "R3 R4 AND pointer");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule